// File: doc/BRIEF.md
# Shared-Bus EPROM Bank Read Controller

This block sits on the host side of a bank of byte-wide UV EPROMs whose data pins are wired together onto one bus. A single read request carries a host address. The upper bits of that address pick one device of the bank. The lower bits go out on the shared address bus. The controller pulls that device's active-low chip select, drives the one output-enable strobe common to the whole bank, and waits out the access times. It then samples the bus, returns the byte with a one-cycle valid strobe, and releases the bus.

The datasheet timings are given in nanoseconds: address-to-data, output-enable-to-data and output float. Each one is a parameter and is turned into whole clock cycles by rounding up against a clock-period parameter. The output enable is not asserted at the start of a read. It is held back until the latest moment that still satisfies the output-enable access time, so it is low for the shortest span. After every read, the controller stays busy for the float interval. This ensures the next device cannot start driving the shared bus while the previous one may still be driving it.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released, all chip selects and the output enable are high, and busy and the valid strobe are low.
- R2: A read drives low only the chip select whose bit index equals the host address bits above the device address field (bits `ADDR_W` and up). All other chip selects stay high, and at no time is more than one chip select low.
- R3: The shared output enable is low only while a chip select is low. It falls LATE = ACC − OE cycles after the launch edge, where ACC = ceil(`T_ACC_NS`/`CLK_NS`) and OE = ceil(`T_OE_NS`/`CLK_NS`).
- R4: The bus is sampled at the clock edge ACC cycles after the launch edge. The sampled byte appears on the read data output together with a valid strobe that lasts exactly one cycle.
- R5: The device address bus carries the lower `ADDR_W` bits of the request and holds them unchanged from the launch edge through the sampling edge.
- R6: At the sampling edge, every chip select and the output enable return high. Busy then stays high for DF = ceil(`T_DF_NS`/`CLK_NS`) further cycles after the valid strobe, and then drops.
- R7: A request that arrives while busy is high is ignored. It produces no read, no valid strobe and no change of address or chip select.
- R8: Between the cycle a device stops driving the bus and the cycle the output enable next falls, at least DF cycles pass. This holds even when consecutive reads target different devices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request, sampled when busy is low |
| addr | input | ADDR_W+log2(N_DEV) | Host byte address; the upper bits select the device |
| busy | output | 1 | High from the launch edge until the float interval has elapsed |
| rdata | output | DATA_W | Captured read byte |
| rvalid | output | 1 | One-cycle strobe qualifying rdata |
| mem_addr | output | ADDR_W | Shared device address bus |
| mem_ce_n | output | N_DEV | Per-device chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq | input | DATA_W | Shared device data bus |

## Verification
The bench's memory model returns the true byte only after it has seen the chip select and address held stable for the full address-access time and the output enable held low for the output-enable time. Before that it returns the complement of the byte. Because of this, a capture even one cycle early, or an output enable asserted too late, shows up as a data mismatch and is not hidden by a correct-looking strobe.

Reads are made to every device, at the lowest and the highest device address. They are issued back to back, both alternating between devices and repeating one device, so that the float spacing is exercised against the next output-enable fall. Requests held high during an access show that busy masks them.

// File: rtl/eprd_pkg.sv
package eprd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } eprd_state_e;

   // whole cycles covering a nanosecond interval (round up)
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
      return (ns + per_ns - 1) / per_ns;
   endfunction

endpackage

// File: rtl/eprd_sel_dec.sv
module eprd_sel_dec #(
   parameter int unsigned N_DEV = 4,
   localparam int unsigned DEV_W = $clog2(N_DEV)
) (
   input  logic [DEV_W-1:0] idx,
   input  logic             en,
   output logic [N_DEV-1:0] sel_n
);

   for (genvar i = 0; i < N_DEV; i++) begin : g_sel
      assign sel_n[i] = ~(en && (idx == DEV_W'(i)));
   end

endmodule

// File: rtl/eprd_tick.sv
module eprd_tick #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (en)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
   import eprd_pkg::*;
#(
   parameter int unsigned CLK_NS   = 5,
   parameter int unsigned T_ACC_NS = 170,
   parameter int unsigned T_OE_NS  = 70,
   parameter int unsigned T_DF_NS  = 35,
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned N_DEV    = 4,
   parameter int unsigned DATA_W   = 8,
   localparam int unsigned DEV_W   = $clog2(N_DEV),
   localparam int unsigned HOST_AW = ADDR_W + DEV_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req,
   input  logic [HOST_AW-1:0] addr,
   output logic               busy,
   output logic [DATA_W-1:0]  rdata,
   output logic               rvalid,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [N_DEV-1:0]   mem_ce_n,
   output logic               mem_oe_n,
   input  logic [DATA_W-1:0]  mem_dq
);

   // cycle counts derived from the nanosecond timings
   localparam int unsigned ACC_C  = ns_to_cyc(T_ACC_NS, CLK_NS);
   localparam int unsigned OE_C   = ns_to_cyc(T_OE_NS, CLK_NS);
   localparam int unsigned DF_C   = ns_to_cyc(T_DF_NS, CLK_NS);
   localparam int unsigned LATE_C = (ACC_C >= OE_C) ? ACC_C - OE_C : 0;
   localparam int unsigned MAX_C  = (ACC_C > DF_C) ? ACC_C : DF_C;
   localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

   localparam logic [CNT_W-1:0] ACC_LAST  = CNT_W'(ACC_C - 1);
   localparam logic [CNT_W-1:0] DF_LAST   = CNT_W'(DF_C - 1);
   localparam logic [CNT_W-1:0] LATE_LAST = CNT_W'((LATE_C == 0) ? 0 : LATE_C - 1);

   // elaboration-time parameter checks
   if (CLK_NS == 0) begin : g_bad_clk
      $error("CLK_NS must be non-zero");
   end
   if (N_DEV < 2 || (1 << DEV_W) != N_DEV) begin : g_bad_ndev
      $error("N_DEV must be a power of two, at least 2");
   end
   if (OE_C < 1 || ACC_C < OE_C) begin : g_bad_acc
      $error("need 1 <= output-enable cycles <= access cycles");
   end
   if (DF_C < 1) begin : g_bad_df
      $error("float time must round to at least one cycle");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("bus widths must be non-zero");
   end

   eprd_state_e      st;
   logic [CNT_W-1:0] cnt;
   logic [N_DEV-1:0] dec_n;
   logic             launch;
   logic             capture;
   logic             float_done;
   logic             oe_at_launch;
   logic             oe_fire;

   assign launch     = (st == ST_IDLE) && req;
   assign capture    = (st == ST_ACCESS) && (cnt == ACC_LAST);
   assign float_done = (st == ST_FLOAT) && (cnt == DF_LAST);
   assign busy       = (st != ST_IDLE);

   // output enable either with the chip select or deferred to the late point
   if (LATE_C == 0) begin : g_oe_early
      assign oe_at_launch = 1'b1;
      assign oe_fire      = 1'b0;
   end else begin : g_oe_late
      assign oe_at_launch = 1'b0;
      assign oe_fire      = (st == ST_ACCESS) && (cnt == LATE_LAST);
   end

   eprd_sel_dec #(
      .N_DEV(N_DEV)
   ) u_dec (
      .idx  (addr[HOST_AW-1:ADDR_W]),
      .en   (1'b1),
      .sel_n(dec_n)
   );

   eprd_tick #(
      .W(CNT_W)
   ) u_tick (
      .clk(clk),
      .rst(rst),
      .clr(launch || capture),
      .en (busy),
      .cnt(cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         mem_addr <= '0;
         mem_ce_n <= '1;
         mem_oe_n <= 1'b1;
         rdata    <= '0;
         rvalid   <= 1'b0;
      end else begin
         rvalid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req) begin
                  st       <= ST_ACCESS;
                  mem_addr <= addr[ADDR_W-1:0];
                  mem_ce_n <= dec_n;
                  mem_oe_n <= ~oe_at_launch;
               end
            end
            ST_ACCESS: begin
               if (oe_fire)
                  mem_oe_n <= 1'b0;
               if (capture) begin
                  rdata    <= mem_dq;
                  rvalid   <= 1'b1;
                  mem_ce_n <= '1;
                  mem_oe_n <= 1'b1;
                  st       <= ST_FLOAT;
               end
            end
            ST_FLOAT: begin
               if (float_done)
                  st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eprd_chk.sv
module eprd_chk #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned N_DEV  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              req,
   input logic              busy,
   input logic              rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [N_DEV-1:0]  mem_ce_n,
   input logic              mem_oe_n
);

   p_one_select_r2: assert property (@(posedge clk) disable iff (rst)
      $countones(~mem_ce_n) <= 1);

   p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (mem_ce_n != '1));

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
      rvalid |=> !rvalid);

   p_addr_held_r5: assert property (@(posedge clk) disable iff (rst)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

   p_release_at_capture_r6: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> (mem_ce_n == '1) && mem_oe_n && busy);

   p_launch_sets_busy_r7: assert property (@(posedge clk) disable iff (rst)
      (req && !busy) |=> busy);

   p_busy_masks_select_r7: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && (mem_ce_n != '1) && ($past(mem_ce_n) != '1)) |-> $stable(mem_ce_n));

endmodule

bind eprom_rd_ctrl eprd_chk #(
   .ADDR_W(ADDR_W),
   .N_DEV (N_DEV)
) u_eprd_chk (
   .clk     (clk),
   .rst     (rst),
   .req     (req),
   .busy    (busy),
   .rvalid  (rvalid),
   .mem_addr(mem_addr),
   .mem_ce_n(mem_ce_n),
   .mem_oe_n(mem_oe_n)
);

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;

   localparam int AW   = 15;
   localparam int ND   = 4;
   localparam int HW   = AW + 2;
   localparam int PER  = 5;
   localparam int ACC  = (170 + PER - 1) / PER;
   localparam int OE   = (70 + PER - 1) / PER;
   localparam int DF   = (35 + PER - 1) / PER;
   localparam int LATE = ACC - OE;

   typedef struct {
      logic [HW-1:0] a;
      logic [7:0]    exp;
      int            launch;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic [HW-1:0] addr = '0;
   logic          busy;
   logic [7:0]    rdata;
   logic          rvalid;
   logic [AW-1:0] mem_addr;
   logic [ND-1:0] mem_ce_n;
   logic          mem_oe_n;
   logic [7:0]    dq_drv = 8'h00;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int n_push = 0;
   int n_pop  = 0;
   int rv_cyc = -1000;
   item_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   eprom_rd_ctrl i_eprom_rd_ctrl (
      .clk(clk), .rst(rst), .req(req), .addr(addr), .busy(busy),
      .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(dq_drv)
   );

   function automatic logic [7:0] rom(input int dev, input logic [AW-1:0] a);
      return a[7:0] ^ {a[14:8], 1'b0} ^ (8'h35 * 8'(dev));
   endfunction

   task automatic chk(input bit ok, input string req_tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req_tag, act, expv, cyc);
      end
   endtask

   // memory model: true byte only after full access and oe times
   logic [ND-1:0] p_ce = '1;
   logic [AW-1:0] p_a  = '0;
   logic          p_oe = 1'b1;
   bit            p_drv = 1'b0;
   int acc_cnt = 0, oe_cnt = 0, rel_cnt = 0;
   always @(negedge clk) begin
      int dev, nsel;
      bit drv;
      nsel = 0; dev = 0;
      for (int i = 0; i < ND; i++) if (!mem_ce_n[i]) begin nsel++; dev = i; end
      if (mem_ce_n == p_ce && mem_addr == p_a) acc_cnt = (acc_cnt < 1000) ? acc_cnt + 1 : acc_cnt;
      else acc_cnt = 1;
      if (!mem_oe_n) oe_cnt = (!p_oe && oe_cnt < 1000) ? oe_cnt + 1 : 1;
      else oe_cnt = 0;
      drv = (nsel == 1) && !mem_oe_n;
      if (p_drv && !drv) rel_cnt = 1;
      else if (rel_cnt != 0 && rel_cnt < 1000) rel_cnt++;
      // R8: spacing from previous bus release to next output-enable fall
      if (p_oe && !mem_oe_n && rel_cnt != 0)
         chk(rel_cnt > DF, "R8 float spacing", rel_cnt, DF + 1);
      if (nsel == 1)
         dq_drv <= (!mem_oe_n && acc_cnt >= ACC && oe_cnt >= OE) ? rom(dev, mem_addr) : ~rom(dev, mem_addr);
      else
         dq_drv <= 8'h00;
      p_ce = mem_ce_n; p_a = mem_addr; p_oe = mem_oe_n; p_drv = drv;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (rvalid) begin
            if (q.size() == 0) chk(1'b0, "R7 unexpected strobe", 1, 0);
            else begin
               chk(rdata == q[0].exp, "R4 data", rdata, q[0].exp);
               chk(cyc - q[0].launch == ACC, "R4 latency", cyc - q[0].launch, ACC);
               chk(mem_ce_n == '1 && mem_oe_n, "R6 release", {mem_ce_n, mem_oe_n}, 5'h1f);
               void'(q.pop_front());
               n_pop++;
            end
            rv_cyc = cyc;
         end else if (q.size() != 0) begin
            int d;
            logic [ND-1:0] sel;
            d = cyc - q[0].launch;
            sel = ~(ND'(1) << q[0].a[HW-1:AW]);
            if (d == 1 || d == ACC - 1) begin
               chk(mem_ce_n == sel, "R2 select", mem_ce_n, sel);
               chk(mem_addr == q[0].a[AW-1:0], "R5 address", mem_addr, q[0].a[AW-1:0]);
            end
            if (LATE > 0 && d == LATE - 1) chk(mem_oe_n == 1'b1, "R3 oe early", mem_oe_n, 1);
            if (d == LATE || d == ACC - 1) chk(mem_oe_n == 1'b0, "R3 oe low", mem_oe_n, 0);
         end
         if (cyc - rv_cyc == DF - 1) chk(busy == 1'b1, "R6 busy in float", busy, 1);
         if (cyc - rv_cyc == DF)     chk(busy == 1'b0, "R6 busy drop", busy, 0);
      end
   end

   task automatic do_read(input int dev, input logic [AW-1:0] a);
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      req  = 1'b1;
      addr = {2'(dev), a};
      @(negedge clk);
      req = 1'b0;
      it.a = {2'(dev), a};
      it.exp = rom(dev, a);
      it.launch = cyc;
      q.push_back(it);
      n_push++;
   endtask

   // R7: hold a request high for several cycles while an access is running
   task automatic poke_busy();
      @(negedge clk);
      req  = 1'b1;
      addr = {2'd2, 15'h1234};
      repeat (5) @(negedge clk);
      req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      chk(mem_ce_n == '1 && mem_oe_n && !busy && !rvalid, "R1 in reset", {mem_ce_n, mem_oe_n, busy, rvalid}, 7'h7c);
      req = 1'b0;
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(mem_ce_n == '1 && mem_oe_n && !busy && !rvalid, "R1 after reset", {mem_ce_n, mem_oe_n, busy, rvalid}, 7'h7c);
      do_read(0, 15'h0000);
      do_read(3, 15'h7fff);
      do_read(1, 15'h2a55);
      do_read(2, 15'h0f0f);
      do_read(1, 15'h2a56);
      do_read(1, 15'h2a57);
      do_read(0, 15'h4001);
      do_read(3, 15'h1111);
      poke_busy();
      do_read(2, 15'h7ffe);
      repeat (ACC + DF + 10) @(negedge clk);
      chk(n_pop == n_push && q.size() == 0, "R7 strobe count", n_pop, n_push);
      chk(!busy && mem_ce_n == '1, "R6 idle at end", busy, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule